// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block is the digital front end of a two-channel 12-bit converter. One serial data line fills a 24-bit shift chain on the falling edge of the shift clock, but only while the select input is low. Two active-low load strobes are sampled on the same edge. Each strobe copies one half of the chain into that channel's 12-bit code register, and both strobes together update both channels in the same edge.

Inside the chain each half is stored in reverse bit order. Each channel output applies the reversal, so it shows its code with bit 11 as the MSB. A full 24-bit frame is sent channel B first, MSB first, then channel A, MSB first. An active-low clear zeroes the chain and both code registers at once, with no regard to the clock, the select input or the strobes.

Top module: `serial_dual_dac_loader`

## Requirements
- R1: On each falling edge of `shift_clk` with `sel_n` low, the bit on `ser_data` enters chain position 23 and every earlier bit moves one position toward 0.
- R2: On a falling edge with `sel_n` high, the chain and both code outputs keep their values, whatever the load strobes and the data line do.
- R3: While `clr_n` is low, the chain, `code_a` and `code_b` are zero immediately, with no clock edge needed.
- R4: A falling edge with `sel_n` low, `ld_a_n` low and `ld_b_n` high sets `code_a[i]` to chain position 23-i. Position 23 becomes the LSB and position 12 becomes the MSB. `code_b` is unchanged.
- R5: A falling edge with `sel_n` low, `ld_b_n` low and `ld_a_n` high sets `code_b[i]` to chain position 11-i. Position 11 becomes the LSB and position 0 becomes the MSB. `code_a` is unchanged.
- R6: A falling edge with `sel_n` low and both strobes low updates both outputs from their halves on that same edge.
- R7: A load takes the chain contents from before the shift made on the same edge.
- R8: After 24 selected edges carrying frame F (bit 23 of F first), a load of both channels gives `code_b` = F[23:12] and `code_a` = F[11:0].
- R9: A channel whose strobe is high at an edge keeps its code, even while the other channel loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, active on the falling edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel_n | input | 1 | Select, active low; enables shifting and loading |
| ser_data | input | 1 | Serial data bit |
| ld_a_n | input | 1 | Load strobe for channel A, active low |
| ld_b_n | input | 1 | Load strobe for channel B, active low |
| code_a | output | 12 | Channel A code, bit 11 = MSB |
| code_b | output | 12 | Channel B code, bit 11 = MSB |

## Verification
The hardest case to reach from the ports is an edge that shifts and loads at once. The load must take the chain as it stood before that edge's shift (R7). The stimulus ends a frame with a combined shift-and-load edge, then loads again without a new frame, so the one-position difference between the two results shows at the outputs. Clears are also dropped partway through frames, and a random sweep covers every select and strobe combination on every edge, so the data that R1 leaves in the chain can only be seen through later loads.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_A    = 2'd1,
    LD_B    = 2'd2,
    LD_BOTH = 2'd3
  } load_mode_e;

  // Strobe decode: nothing moves while the select input is high.
  function automatic load_mode_e decode_mode(input logic sel_n,
                                             input logic la_n,
                                             input logic lb_n);
    if (sel_n) return LD_NONE;
    return load_mode_e'({!lb_n, !la_n});
  endfunction
endpackage

// File: rtl/dacfe_shifter.sv
`timescale 1ns/1ps
module dacfe_shifter #(
  parameter int LEN = 24
) (
  input  logic           shift_clk,
  input  logic           clr_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] chain_q
);
  // A new bit enters at the top position; older bits move toward position 0.
  always_ff @(negedge shift_clk or negedge clr_n) begin
    if (!clr_n)        chain_q <= '0;
    else if (shift_en) chain_q <= {din, chain_q[LEN-1:1]};
  end
endmodule

// File: rtl/dacfe_hold.sv
`timescale 1ns/1ps
module dacfe_hold #(
  parameter int W = 12
) (
  input  logic         shift_clk,
  input  logic         clr_n,
  input  logic         load,
  input  logic [W-1:0] half_raw,
  output logic [W-1:0] code_q
);
  // The top position of the half is the LSB of the code.
  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  always_ff @(negedge shift_clk or negedge clr_n) begin
    if (!clr_n)    code_q <= '0;
    else if (load) code_q <= flip(half_raw);
  end
endmodule

// File: rtl/serial_dual_dac_loader.sv
`timescale 1ns/1ps
module serial_dual_dac_loader #(
  parameter int CH_W = 12
) (
  input  logic            shift_clk,
  input  logic            clr_n,
  input  logic            sel_n,
  input  logic            ser_data,
  input  logic            ld_a_n,
  input  logic            ld_b_n,
  output logic [CH_W-1:0] code_a,
  output logic [CH_W-1:0] code_b
);
  import dacfe_pkg::*;

  localparam int NCH = 2;
  localparam int LEN = NCH * CH_W;

  load_mode_e           mode;
  logic                 shift_en;
  logic [NCH-1:0]       load_vec;
  logic [LEN-1:0]       sr_q;
  logic [CH_W-1:0]      code_arr [NCH];

  assign mode     = decode_mode(sel_n, ld_a_n, ld_b_n);
  assign shift_en = !sel_n;
  assign load_vec = mode;   // bit 0: channel A, bit 1: channel B

  dacfe_shifter #(.LEN(LEN)) u_shift (
    .shift_clk (shift_clk),
    .clr_n     (clr_n),
    .shift_en  (shift_en),
    .din       (ser_data),
    .chain_q   (sr_q)
  );

  // Channel 0 (A) takes the upper half, channel 1 (B) the lower half.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dacfe_hold #(.W(CH_W)) u_hold (
      .shift_clk (shift_clk),
      .clr_n     (clr_n),
      .load      (load_vec[ch]),
      .half_raw  (sr_q[(NCH-ch)*CH_W-1 -: CH_W]),
      .code_q    (code_arr[ch])
    );
  end

  assign code_a = code_arr[0];
  assign code_b = code_arr[1];
endmodule

// File: rtl/dacfe_checker.sv
`timescale 1ns/1ps
module dacfe_checker #(
  parameter int CH_W = 12
) (
  input logic              shift_clk,
  input logic              clr_n,
  input logic              sel_n,
  input logic              ser_data,
  input logic              ld_a_n,
  input logic              ld_b_n,
  input logic [2*CH_W-1:0] sr_q,
  input logic [CH_W-1:0]   code_a,
  input logic [CH_W-1:0]   code_b
);
  localparam int LEN = 2 * CH_W;

  function automatic logic [CH_W-1:0] rev(input logic [CH_W-1:0] v);
    logic [CH_W-1:0] r;
    for (int i = 0; i < CH_W; i++) r[i] = v[CH_W-1-i];
    return r;
  endfunction

  always @(negedge shift_clk) begin
    if (!clr_n)
      assert_clear_zero_R3: assert (sr_q == '0 && code_a == '0 && code_b == '0);
  end

  assert_shift_in_R1: assert property (@(negedge shift_clk) disable iff (!clr_n)
    !sel_n |=> (sr_q[LEN-1] == $past(ser_data)) && (sr_q[LEN-2:0] == $past(sr_q[LEN-1:1])));

  assert_idle_hold_R2: assert property (@(negedge shift_clk) disable iff (!clr_n)
    sel_n |=> $stable(sr_q) && $stable(code_a) && $stable(code_b));

  assert_load_a_R4: assert property (@(negedge shift_clk) disable iff (!clr_n)
    (!sel_n && !ld_a_n) |=> code_a == rev($past(sr_q[LEN-1:CH_W])));

  assert_load_b_R5: assert property (@(negedge shift_clk) disable iff (!clr_n)
    (!sel_n && !ld_b_n) |=> code_b == rev($past(sr_q[CH_W-1:0])));

  assert_keep_a_R9: assert property (@(negedge shift_clk) disable iff (!clr_n)
    ld_a_n |=> $stable(code_a));

  assert_keep_b_R9: assert property (@(negedge shift_clk) disable iff (!clr_n)
    ld_b_n |=> $stable(code_b));
endmodule

bind serial_dual_dac_loader dacfe_checker #(.CH_W(CH_W)) u_chk (
  .shift_clk (shift_clk),
  .clr_n     (clr_n),
  .sel_n     (sel_n),
  .ser_data  (ser_data),
  .ld_a_n    (ld_a_n),
  .ld_b_n    (ld_b_n),
  .sr_q      (sr_q),
  .code_a    (code_a),
  .code_b    (code_b)
);

// File: tb/sim_serial_dual_dac_loader.sv
`timescale 1ns/1ps
module sim_serial_dual_dac_loader;
  logic        shift_clk = 1'b1;
  logic        clr_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        ser_data = 1'b0;
  logic        ld_a_n = 1'b1;
  logic        ld_b_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int fails  = 0;
  logic [23:0] hist = '0;   // bits sent, newest in bit 0
  logic [11:0] exp_a = '0, exp_b = '0;

  always #2.5 shift_clk = ~shift_clk;

  serial_dual_dac_loader u0 (
    .shift_clk (shift_clk), .clr_n (clr_n), .sel_n (sel_n),
    .ser_data (ser_data), .ld_a_n (ld_a_n), .ld_b_n (ld_b_n),
    .code_a (code_a), .code_b (code_b)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive after the rising edge, act on the falling edge, sample after it.
  task automatic cyc(input logic s, input logic d, input logic la, input logic lb,
                     input string req);
    @(posedge shift_clk); #0.5;
    sel_n = s; ser_data = d; ld_a_n = la; ld_b_n = lb;
    @(negedge shift_clk); #1;
    if (!s) begin
      // The older half (sent first) belongs to B; loads see pre-shift history.
      if (!la) exp_a = hist[11:0];
      if (!lb) exp_b = hist[23:12];
      hist = {hist[22:0], d};
    end
    check(req, code_a, exp_a);
    check(req, code_b, exp_b);
  endtask

  task automatic send_frame(input logic [23:0] f);
    for (int i = 23; i >= 0; i--) cyc(1'b0, f[i], 1'b1, 1'b1, "R1");
  endtask

  task automatic do_clear(input logic s, input logic la, input logic lb);
    @(posedge shift_clk); #1;
    sel_n = s; ld_a_n = la; ld_b_n = lb; ser_data = 1'b1;
    clr_n = 1'b0;
    #0.3;
    check("R3 async", code_a, 12'h000);
    check("R3 async", code_b, 12'h000);
    @(negedge shift_clk); #1;
    check("R3 held", code_a, 12'h000);
    check("R3 held", code_b, 12'h000);
    @(posedge shift_clk); #1;
    sel_n = 1'b1; ld_a_n = 1'b1; ld_b_n = 1'b1;
    clr_n = 1'b1;
    hist = '0; exp_a = '0; exp_b = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] f;
    #1;
    check("R3 reset", code_a, 12'h000);
    check("R3 reset", code_b, 12'h000);
    @(posedge shift_clk); #1; clr_n = 1'b1;

    // R8: frame order, then a combined load
    f = 24'hA5C_3E1;
    send_frame(f);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    check("R8 b", code_b, f[23:12]);
    check("R8 a", code_a, f[11:0]);
    // R7: a second load without a new frame sees the chain one place further on
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R7");
    check("R7 a", code_a, {f[10:0], 1'b0});
    check("R7 b", code_b, {f[22:12], f[11]});

    // R2: with select high, strobes and data have no effect
    for (int i = 0; i < 8; i++) cyc(1'b1, i[0], i[1], i[2], "R2");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R2 chain kept");

    // R4, R5, R9: single-channel loads leave the other channel alone
    f = 24'h123_FED;
    send_frame(f);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, "R4 R9");
    check("R4", code_a, f[11:0]);
    f = 24'h9B7_046;
    send_frame(f);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, "R5 R9");
    check("R5", code_b, f[23:12]);

    // R3: clears in the middle of frames, with every strobe combination
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 5 + k; i++) cyc(1'b0, 1'($urandom), 1'b1, 1'b1, "R1");
      do_clear(k[0], k[1], k[2]);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, "R3 chain cleared");
    end

    // Random frames with a load of both channels
    for (int n = 0; n < 40; n++) begin
      f = 24'($urandom);
      send_frame(f);
      cyc(1'b0, 1'($urandom), 1'b0, 1'b0, "R8");
    end

    // Near-exhaustive sweep: every select and strobe combination on random edges
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r[0] & r[3], r[1] ^ r[3], r[2], r[1] & r[0], "R1 R2 R4 R5 R6 R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule